// File: doc/BRIEF.md
# SDRAM Power-Up, Refresh and Self-Refresh Sequencer

This block brings an SDRAM device out of power-up and keeps it alive. A sticky mode enable starts a startup wait long enough to cover the device's 100 µs power-up interval. The block then issues the initialization commands: a precharge of all banks, two auto-refreshes, and a load of a fixed mode word. That word selects CAS latency 2 and full-page bursts. A status output stays high while this sequence runs.

Once initialized, the block issues auto-refresh commands at an interval taken from a live refresh input. It also turns host row requests into ACTIVATE commands with a grant pulse. A two-bit frequency-range code sets how many NOP cycles follow every command. A sleep input puts the device into self-refresh once the host reports no transfer in flight. After wake-up, host requests are held off for a number of cycles that depends on the range. Data bursts and pad timing belong to other blocks.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), CKE is high, and the init-busy flag and the grant are low.
- R2: The first command after enable is a precharge-all (code 0010, address bit 10 high). It appears exactly STARTUP_CYC cycles after the clock edge that first samples the enable high, with only NOPs before it.
- R3: The initialization commands come in this order: precharge-all, auto-refresh (0001), auto-refresh, load-mode (0000). The load-mode carries 0x27 on the address and 0 on the bank pins.
- R4: The init-busy flag is high from the cycle after enable until the cycle before load-mode. It is low from the load-mode cycle onward.
- R5: Every command is followed by a fixed number of NOP cycles set by the range code: 1 for code 0, 1 for code 1, 2 for code 2 and 3 for code 3.
- R6: While idle, auto-refresh repeats every rfsh+1 cycles. The first one comes rfsh+2 cycles after load-mode. A new rfsh value takes effect at the next timer reload.
- R7: A host request causes an ACTIVATE (0011) that carries the request's row and bank, with the grant high in the same cycle. No ACTIVATE is issued before load-mode.
- R8: A pending refresh wins over a host request. Under a continuous host load, no gap between refreshes exceeds rfsh+1 plus the range delay.
- R9: With sleep high and host-busy low, the block enters self-refresh by issuing auto-refresh code 0001 with CKE low. While host-busy is high, CKE stays high.
- R10: In self-refresh, CKE stays low and only NOPs are issued. Refresh requests are dropped. The refresh timer restarts on exit, so the first auto-refresh comes rfsh+2 cycles after CKE rises.
- R11: After sleep drops, CKE rises, and then W NOP cycles pass before the first ACTIVATE. W is 2 for range code 2, 5 for code 3, and 1 for codes 0 and 1.
- R12: Once set, the enable cannot be undone. Lowering the enable input does not stop refresh, does not lower CKE, and does not restart initialization.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_en_i | input | 1 | Mode enable; sticky once seen high |
| range_i | input | 2 | Frequency-range code |
| rfsh_i | input | RFSH_W | Refresh interval value |
| sleep_i | input | 1 | Request self-refresh |
| host_busy_i | input | 1 | Host has a transfer in flight |
| host_req_i | input | 1 | Host row-open request |
| host_row_i | input | ROW_W | Row for the request |
| host_bank_i | input | BANK_W | Bank for the request |
| host_gnt_o | output | 1 | Request accepted (one cycle, with ACTIVATE) |
| init_busy_o | output | 1 | Initialization in progress |
| sdr_cke_o | output | 1 | Clock enable |
| sdr_cs_n_o | output | 1 | Chip select, active low |
| sdr_ras_n_o | output | 1 | Row strobe, active low |
| sdr_cas_n_o | output | 1 | Column strobe, active low |
| sdr_we_n_o | output | 1 | Write enable, active low |
| sdr_addr_o | output | ROW_W | Address pins |
| sdr_ba_o | output | BANK_W | Bank pins |

## Verification
The bench builds the block with STARTUP_CYC set to 40 instead of the 20000 cycles that 100 µs takes at 200 MHz. This lets the full startup wait, the exact placement of the first precharge, and the whole initialization order fit into a short run. Refresh values of 200 and 60 are driven on the input. These show the reload rule, many refresh intervals under idle and saturated host load, and three sleep/wake cycles at range codes 3, 2 and 0, all within a few thousand cycles.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    localparam int DLY_W  = 4;
    localparam int HOLD_W = 3;
    localparam logic [7:0] MODE_WORD = 8'h27;   // CAS latency 2, full-page burst

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAIT_UP,
        ST_AREF1,
        ST_AREF2,
        ST_LOAD,
        ST_READY,
        ST_SLEEP
    } seq_st_e;

endpackage

// File: rtl/sdr_range_decode.sv
module sdr_range_decode
    import sdr_seq_pkg::*;
#(
    parameter int unsigned DLY_R0   = 1,
    parameter int unsigned DLY_R1   = 1,
    parameter int unsigned DLY_R2   = 2,
    parameter int unsigned DLY_R3   = 3,
    parameter int unsigned WAKE_R2  = 2,
    parameter int unsigned WAKE_R3  = 5,
    parameter int unsigned WAKE_DEF = 1
) (
    input  logic [1:0]        range_i,
    output logic [DLY_W-1:0]  step_o,
    output logic [HOLD_W-1:0] wake_o
);

    always_comb begin
        case (range_i)
            2'd0:    step_o = DLY_W'(DLY_R0);
            2'd1:    step_o = DLY_W'(DLY_R1);
            2'd2:    step_o = DLY_W'(DLY_R2);
            default: step_o = DLY_W'(DLY_R3);
        endcase
    end

    always_comb begin
        case (range_i)
            2'd2:    wake_o = HOLD_W'(WAKE_R2);
            2'd3:    wake_o = HOLD_W'(WAKE_R3);
            default: wake_o = HOLD_W'(WAKE_DEF);
        endcase
    end

endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int RFSH_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              load_i,
    input  logic              ack_i,
    input  logic [RFSH_W-1:0] rfsh_i,
    output logic              pend_o
);

    typedef struct packed {
        logic [RFSH_W-1:0] tmr;
        logic              pend;
    } tmr_s;

    tmr_s tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.tmr  = rfsh_i;
            tmr_d.pend = 1'b0;
        end else if (!run_i) begin
            tmr_d.pend = 1'b0;                 // requests dropped while parked
        end else if (tmr_q.tmr == '0) begin
            tmr_d.tmr  = rfsh_i;
            tmr_d.pend = 1'b1;
        end else begin
            tmr_d.tmr  = tmr_q.tmr - 1'b1;
            tmr_d.pend = tmr_q.pend & ~ack_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign pend_o = tmr_q.pend;

    // R10: no request survives a cycle outside the ready state
    a_r10_drop_when_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> !pend_o);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdr_seq_pkg::*;
#(
    parameter int STARTUP_CYC = 20000,
    parameter int RFSH_W      = 12,
    parameter int ROW_W       = 13,
    parameter int BANK_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en_i,
    input  logic [1:0]        range_i,
    input  logic [RFSH_W-1:0] rfsh_i,
    input  logic              sleep_i,
    input  logic              host_busy_i,
    input  logic              host_req_i,
    input  logic [ROW_W-1:0]  host_row_i,
    input  logic [BANK_W-1:0] host_bank_i,
    output logic              host_gnt_o,
    output logic              init_busy_o,
    output logic              sdr_cke_o,
    output logic              sdr_cs_n_o,
    output logic              sdr_ras_n_o,
    output logic              sdr_cas_n_o,
    output logic              sdr_we_n_o,
    output logic [ROW_W-1:0]  sdr_addr_o,
    output logic [BANK_W-1:0] sdr_ba_o
);

    localparam int CNT_W = $clog2(STARTUP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STARTUP_CYC - 1);
    localparam logic [ROW_W-1:0] ALL_BANKS = ROW_W'(1) << 10;

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [DLY_W-1:0]  gap;
        logic [HOLD_W-1:0] hold;
        sdr_cmd_e          cmd;
        logic              cke;
        logic [ROW_W-1:0]  addr;
        logic [BANK_W-1:0] ba;
        logic              busy;
        logic              gnt;
    } seq_s;

    seq_s seq_q, seq_d;

    logic [DLY_W-1:0]  step_dly;
    logic [HOLD_W-1:0] wake_dly;
    logic              ref_pend;
    logic              tmr_load;
    logic              ref_ack;
    logic              tmr_run;

    sdr_range_decode u_range (
        .range_i (range_i),
        .step_o  (step_dly),
        .wake_o  (wake_dly)
    );

    assign tmr_run = (seq_q.st == ST_READY);

    sdr_refresh_timer #(.RFSH_W(RFSH_W)) u_rfsh (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (tmr_run),
        .load_i (tmr_load),
        .ack_i  (ref_ack),
        .rfsh_i (rfsh_i),
        .pend_o (ref_pend)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.cmd = CMD_NOP;
        seq_d.gnt = 1'b0;
        tmr_load  = 1'b0;
        ref_ack   = 1'b0;

        if (seq_q.hold != '0) seq_d.hold = seq_q.hold - 1'b1;

        if (seq_q.gap != '0) begin
            seq_d.gap = seq_q.gap - 1'b1;
        end else begin
            case (seq_q.st)
                ST_OFF: begin
                    if (mode_en_i) begin
                        seq_d.st   = ST_WAIT_UP;
                        seq_d.cnt  = CNT_LAST;
                        seq_d.busy = 1'b1;
                    end
                end
                ST_WAIT_UP: begin
                    if (seq_q.cnt == '0) begin
                        seq_d.cmd  = CMD_PRE;
                        seq_d.addr = ALL_BANKS;
                        seq_d.st   = ST_AREF1;
                        seq_d.gap  = step_dly;
                    end else begin
                        seq_d.cnt = seq_q.cnt - 1'b1;
                    end
                end
                ST_AREF1: begin
                    seq_d.cmd = CMD_REF;
                    seq_d.st  = ST_AREF2;
                    seq_d.gap = step_dly;
                end
                ST_AREF2: begin
                    seq_d.cmd = CMD_REF;
                    seq_d.st  = ST_LOAD;
                    seq_d.gap = step_dly;
                end
                ST_LOAD: begin
                    seq_d.cmd  = CMD_LMR;
                    seq_d.addr = ROW_W'(MODE_WORD);
                    seq_d.ba   = '0;
                    seq_d.busy = 1'b0;
                    seq_d.st   = ST_READY;
                    seq_d.gap  = step_dly;
                    tmr_load   = 1'b1;
                end
                ST_READY: begin
                    if (ref_pend) begin
                        seq_d.cmd = CMD_REF;
                        seq_d.gap = step_dly;
                        ref_ack   = 1'b1;
                    end else if (sleep_i && !host_busy_i) begin
                        seq_d.cmd = CMD_REF;
                        seq_d.cke = 1'b0;
                        seq_d.st  = ST_SLEEP;
                    end else if (host_req_i && seq_q.hold == '0) begin
                        seq_d.cmd  = CMD_ACT;
                        seq_d.addr = host_row_i;
                        seq_d.ba   = host_bank_i;
                        seq_d.gnt  = 1'b1;
                        seq_d.gap  = step_dly;
                    end
                end
                ST_SLEEP: begin
                    if (!sleep_i) begin
                        seq_d.cke  = 1'b1;
                        seq_d.hold = wake_dly;
                        seq_d.st   = ST_READY;
                        tmr_load   = 1'b1;
                    end
                end
                default: seq_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_OFF;
            seq_q.cmd  <= CMD_NOP;
            seq_q.cke  <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign {sdr_cs_n_o, sdr_ras_n_o, sdr_cas_n_o, sdr_we_n_o} = seq_q.cmd;
    assign sdr_cke_o   = seq_q.cke;
    assign sdr_addr_o  = seq_q.addr;
    assign sdr_ba_o    = seq_q.ba;
    assign init_busy_o = seq_q.busy;
    assign host_gnt_o  = seq_q.gnt;

    // R2: nothing but NOP while the startup wait runs
    a_r2_quiet_startup: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAIT_UP) |-> (seq_q.cmd == CMD_NOP));

    // R3: the mode load always carries the fixed word
    a_r3_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd == CMD_LMR) |-> (sdr_addr_o == ROW_W'(MODE_WORD)));

    // R4: busy only drops together with the mode load
    a_r4_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_busy_o) |-> (seq_q.cmd == CMD_LMR));

    // R5: every command is followed by at least one NOP
    a_r5_gap_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.cmd != CMD_NOP) |=> (seq_q.cmd == CMD_NOP));

    // R7: grant only with an ACTIVATE
    a_r7_gnt_act: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt_o |-> (seq_q.cmd == CMD_ACT));

    // R9: no self-refresh entry while a transfer is in flight
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy_i && sdr_cke_o) |=> sdr_cke_o);

    // R11: no grant while the wake holdoff runs
    a_r11_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.hold != '0) |=> !host_gnt_o);

    // R12: once started the sequencer never returns to off
    a_r12_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_OFF) |=> (seq_q.st != ST_OFF));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;

    localparam int S_CYC  = 40;
    localparam int RFSH_W = 12;
    localparam int ROW_W  = 13;
    localparam int BANK_W = 2;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_ACT = 4'b0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_en = 1'b0;
    logic [1:0] range = 2'd2;
    logic [RFSH_W-1:0] rfsh = 12'd200;
    logic sleep = 1'b0;
    logic host_busy = 1'b0;
    logic host_req = 1'b0;
    logic [ROW_W-1:0] host_row = 13'h0abc;
    logic [BANK_W-1:0] host_bank = 2'd3;
    logic gnt, busy, cke, cs_n, ras_n, cas_n, we_n;
    logic [ROW_W-1:0] addr;
    logic [BANK_W-1:0] ba;
    logic [3:0] cmd_w;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cmd_w = {cs_n, ras_n, cas_n, we_n};

    sdram_init_seq #(
        .STARTUP_CYC(S_CYC), .RFSH_W(RFSH_W), .ROW_W(ROW_W), .BANK_W(BANK_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en_i(mode_en), .range_i(range),
        .rfsh_i(rfsh), .sleep_i(sleep), .host_busy_i(host_busy),
        .host_req_i(host_req), .host_row_i(host_row), .host_bank_i(host_bank),
        .host_gnt_o(gnt), .init_busy_o(busy), .sdr_cke_o(cke),
        .sdr_cs_n_o(cs_n), .sdr_ras_n_o(ras_n), .sdr_cas_n_o(cas_n),
        .sdr_we_n_o(we_n), .sdr_addr_o(addr), .sdr_ba_o(ba)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_cmd(input int lim, output logic [3:0] c, output int at, output logic pb);
        logic prev;
        prev = busy;
        c = C_NOP; at = -1; pb = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (cmd_w != C_NOP) begin
                c = cmd_w; at = cyc; pb = prev;
                return;
            end
            prev = busy;
        end
    endtask

    function automatic int step_of(input int code);
        return (code == 3) ? 3 : (code == 2) ? 2 : 1;
    endfunction

    function automatic int wake_of(input int code);
        return (code == 3) ? 5 : (code == 2) ? 2 : 1;
    endfunction

    int lmr_t;

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_w == C_NOP, "R1 cmd", cmd_w, C_NOP);
        chk(cke == 1'b1, "R1 cke", cke, 1);
        chk(busy == 1'b0 && gnt == 1'b0, "R1 busy/gnt", {busy, gnt}, 0);
    endtask

    task automatic t_init();
        logic [3:0] c; int at, c0, prv; logic pb;
        range = 2'd2; host_req = 1'b1;
        mode_en = 1'b1; c0 = cyc + 1;
        @(negedge clk);
        mode_en = 1'b0;                         // R12: single-cycle enable
        chk(busy == 1'b1, "R4 busy after enable", busy, 1);
        next_cmd(S_CYC + 10, c, at, pb);
        chk(c == C_PRE && at == c0 + S_CYC, "R2 first precharge time", at, c0 + S_CYC);
        chk(addr[10] == 1'b1, "R2 all-banks bit", addr[10], 1);
        prv = at;
        next_cmd(20, c, at, pb);
        chk(c == C_REF && at == prv + 3, "R3 R5 first refresh", at, prv + 3);
        prv = at;
        next_cmd(20, c, at, pb);
        chk(c == C_REF && at == prv + 3, "R3 R5 second refresh", at, prv + 3);
        prv = at;
        next_cmd(20, c, at, pb);
        chk(c == C_LMR && at == prv + 3, "R3 load-mode time", at, prv + 3);
        chk(addr == 13'h027 && ba == 2'd0, "R3 mode word", addr, 'h27);
        chk(pb == 1'b1 && busy == 1'b0, "R4 busy edge", {pb, busy}, 2);
        lmr_t = at;
        next_cmd(20, c, at, pb);
        chk(c == C_ACT && at == lmr_t + 3 && gnt == 1'b1, "R7 first activate", at, lmr_t + 3);
        chk(addr == host_row && ba == host_bank, "R7 row/bank", addr, host_row);
        host_req = 1'b0;
    endtask

    task automatic t_refresh();
        logic [3:0] c; int at, prv; logic pb;
        next_cmd(400, c, at, pb);
        chk(c == C_REF && at == lmr_t + 202, "R6 first periodic refresh", at, lmr_t + 202);
        prv = at;
        rfsh = 12'd60;
        next_cmd(400, c, at, pb);
        chk(c == C_REF && at == prv + 201, "R6 old interval holds", at - prv, 201);
        prv = at;
        next_cmd(400, c, at, pb);
        chk(c == C_REF && at == prv + 61, "R6 new interval", at - prv, 61);
    endtask

    task automatic t_range();
        logic [3:0] c; int at, prv; logic pb;
        for (int code = 0; code < 4; code++) begin
            range = 2'(code);
            next_cmd(200, c, at, pb);
            chk(c == C_REF, "R5 sync refresh", c, C_REF);
            host_req = 1'b1;
            host_row = 13'(16'h0100 + code);
            prv = at;
            next_cmd(20, c, at, pb);
            chk(c == C_ACT && at == prv + step_of(code) + 1, "R5 refresh-to-activate", at - prv, step_of(code) + 1);
            prv = at;
            next_cmd(20, c, at, pb);
            chk(c == C_ACT && at == prv + step_of(code) + 1, "R5 activate spacing", at - prv, step_of(code) + 1);
            chk(addr == host_row, "R7 row per code", addr, host_row);
            host_req = 1'b0;
        end
    endtask

    task automatic t_priority();
        int last, worst, nref, nact;
        range = 2'd3; host_req = 1'b1;
        last = cyc; worst = 0; nref = 0; nact = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (cmd_w == C_ACT) nact++;
            if (cmd_w == C_REF) begin
                if (nref > 0 && cyc - last > worst) worst = cyc - last;
                last = cyc; nref++;
            end
        end
        host_req = 1'b0;
        chk(nref >= 6 && nact > 0, "R8 refresh under load", nref, 6);
        chk(worst <= 61 + 3, "R8 worst refresh gap", worst, 64);
    endtask

    task automatic t_sleep(input int code);
        logic [3:0] c; int at, x, bad; logic pb, hit;
        range = 2'(code);
        host_busy = 1'b1; sleep = 1'b1;
        bad = 0;
        repeat (20) begin @(negedge clk); if (cke != 1'b1) bad++; end
        chk(bad == 0, "R9 busy holds off entry", bad, 0);
        host_busy = 1'b0;
        hit = 1'b0;
        for (int i = 0; i < 10 && !hit; i++) begin
            @(negedge clk);
            if (cke == 1'b0) begin
                hit = 1'b1;
                chk(cmd_w == C_REF, "R9 entry command", cmd_w, C_REF);
            end
        end
        chk(hit, "R9 entry seen", hit, 1);
        bad = 0;
        repeat (300) begin @(negedge clk); if (cke != 1'b0 || cmd_w != C_NOP) bad++; end
        chk(bad == 0, "R10 quiet self-refresh", bad, 0);
        host_req = 1'b1; sleep = 1'b0; x = cyc;
        @(negedge clk);
        chk(cke == 1'b1 && cmd_w == C_NOP, "R11 exit", {cke, cmd_w}, {1'b1, C_NOP});
        next_cmd(20, c, at, pb);
        chk(c == C_ACT && at == x + wake_of(code) + 2, "R11 wake holdoff", at - x - 2, wake_of(code));
        host_req = 1'b0;
        next_cmd(200, c, at, pb);
        chk(c == C_REF && at == x + 1 + 62, "R10 timer restart", at - x - 1, 62);
    endtask

    task automatic t_sticky();
        int nref, bad;
        nref = 0; bad = 0;
        repeat (150) begin
            @(negedge clk);
            if (cmd_w == C_REF) nref++;
            if (cke != 1'b1 || busy != 1'b0) bad++;
        end
        chk(mode_en == 1'b0 && nref >= 2, "R12 refresh continues", nref, 2);
        chk(bad == 0, "R12 no restart", bad, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_init();
        t_refresh();
        t_range();
        t_priority();
        t_sleep(3);
        t_sleep(2);
        t_sleep(0);
        t_sticky();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

endmodule